// File: doc/BRIEF.md
# SPI EEPROM Access Sequencer

This block sits between a host that wants to read or write a run of bytes in a serial EEPROM and a byte-level SPI engine that moves one byte per request. The host gives a 16-bit start address, a byte count and a direction. The sequencer cuts the request into chunks of at most `CHUNK` bytes and runs the EEPROM command protocol for each chunk: write-enable, then write command, address and data, then status polling until the part finishes its internal write; or read command, address, and one dummy byte per wanted byte with the returned bytes handed to the host. The address advances chunk by chunk.

The SPI side starts one byte at a time with `xfer_start`, and a hold flag tells the engine whether chip select stays asserted after that byte. Write data is pulled from the host one byte per `wdata_take`. Read data is pushed to the host with `rdata_valid`. Status polls are spaced by a gap of `CLK_HZ/1000` clocks (1 ms) and are bounded by `POLL_MAX` tries. A `done` pulse, with `err` on a timeout, ends every request.

The controller is a single state machine. Its states: IDLE (waits for a request), WREN (write-enable byte), OPC (read or write opcode), AHI and ALO (address bytes), DATA (payload or dummy bytes), PSTAT and PDUM (status opcode and dummy byte), GAP (wait between polls), ADV (advance to the next chunk) and FIN (done pulse). Transitions: IDLE to FIN on a zero length, to WREN on a write, to OPC on a read. WREN to OPC, OPC to AHI, AHI to ALO and ALO to DATA each happen when the engine reports the byte done. DATA goes to PSTAT (write) or ADV (read) after the last byte of the chunk. PSTAT goes to PDUM. PDUM goes to ADV when the part is idle, to GAP while busy, and to FIN when the tries are used up. GAP goes to PSTAT when the gap expires. ADV goes to FIN after the last chunk, otherwise to WREN or OPC. FIN goes to IDLE.

Top module: `spi_eep_seq`

## Requirements
- R1: A request with length zero gives `done` high with `err` low in the cycle after it is accepted, and starts no SPI byte.
- R2: Every write chunk begins with its own one-byte transaction carrying 0x06.
- R3: A write chunk transaction sends 0x02, then the address high byte, then the address low byte, then the chunk's data bytes in the order the host supplies them through `wdata_take`.
- R4: A read chunk transaction sends 0x03, the address high byte, the address low byte, then one 0x00 byte per wanted byte. The bytes received from the fourth byte on go to the host on `rdata_valid`, in order.
- R5: After each write chunk the block runs two-byte status transactions (0x05, then 0x00). It repeats them while bit 0 of the second received byte is 1, and moves on once that bit is 0. No other bit of that byte matters.
- R6: Two successive status transactions of one chunk start at least `CLK_HZ/1000` clock cycles apart.
- R7: If the busy bit is still 1 after `POLL_MAX` status transactions, the block stops the request with no further SPI traffic and gives `done` together with `err` high. The next request starts with `err` cleared.
- R8: A request is split into chunks of `CHUNK` bytes, and the last chunk carries the remainder. Each chunk's address is the previous chunk's address plus its length, wrapping modulo 2^16.
- R9: `xfer_hold_cs` is 1 on every byte of a transaction except its last byte, so each transaction ends where the hold flag is 0.
- R10: `xfer_start` is a one-cycle pulse, and no new byte starts until the engine signals `xfer_done`. `busy` stays high from acceptance until `done`, and a request that arrives while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `err` and `xfer_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | Start address in the EEPROM |
| req_len | input | LEN_W | Number of bytes |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Status-poll timeout, valid with `done` |
| wdata | input | 8 | Next write byte from the host |
| wdata_take | output | 1 | `wdata` is consumed this cycle |
| rdata | output | 8 | Read byte to the host |
| rdata_valid | output | 1 | `rdata` is valid this cycle |
| xfer_start | output | 1 | Start one SPI byte |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_hold_cs | output | 1 | Keep chip select asserted after this byte |
| xfer_done | input | 1 | Engine finished the byte |
| xfer_rx | input | 8 | Byte shifted in, valid with `xfer_done` |

## Verification
The bench builds the sequencer with `CLK_HZ` of 16000, so the poll gap is 16 cycles. That keeps the spacing between polls measurable and the timeout test short. `POLL_MAX` is 4, so the timeout path is reached after four busy answers rather than a thousand. `CHUNK` stays 16 and `LEN_W` is 8. Requests of 20 and 37 bytes therefore cross chunk boundaries, one starting at 0xFFF0 wraps the address, and a 16-byte request lands exactly on one full chunk.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_OPC,
        ST_AHI,
        ST_ALO,
        ST_DATA,
        ST_PSTAT,
        ST_PDUM,
        ST_GAP,
        ST_ADV,
        ST_FIN
    } seq_state_t;

    localparam logic [7:0] OP_WR_ENABLE = 8'h06;
    localparam logic [7:0] OP_WRITE     = 8'h02;
    localparam logic [7:0] OP_READ      = 8'h03;
    localparam logic [7:0] OP_STATUS    = 8'h05;
    localparam logic [7:0] FILL_BYTE    = 8'h00;

endpackage

// File: rtl/spi_eep_chunker.sv
module spi_eep_chunker #(
    parameter int CHUNK = 16,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [15:0]      addr_in,
    input  logic [LEN_W-1:0] len_in,
    output logic [15:0]      cur_addr,
    output logic [LEN_W-1:0] chunk_len,
    output logic             last_chunk
);
    localparam logic [LEN_W-1:0] CH = LEN_W'(CHUNK);

    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= addr_in;
            remain   <= len_in;
        end else if (adv) begin
            cur_addr <= cur_addr + 16'(chunk_len);
            remain   <= remain - chunk_len;
        end
    end

    assign chunk_len  = (remain > CH) ? CH : remain;
    assign last_chunk = (remain <= CH);

endmodule

// File: rtl/spi_eep_gap.sv
module spi_eep_gap #(
    parameter int CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= CW'(CYCLES - 1);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/spi_eep_seq.sv
module spi_eep_seq
    import spi_eep_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int POLL_MAX = 1000,
    parameter int CHUNK    = 16,
    parameter int LEN_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [15:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    output logic             done,
    output logic             err,
    input  logic [7:0]       wdata,
    output logic             wdata_take,
    output logic [7:0]       rdata,
    output logic             rdata_valid,
    output logic             xfer_start,
    output logic [7:0]       xfer_tx,
    output logic             xfer_hold_cs,
    input  logic             xfer_done,
    input  logic [7:0]       xfer_rx
);
    localparam int GAP_CYC = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
    localparam int PW      = $clog2(POLL_MAX + 1);

    seq_state_t       state, nxt;
    logic             launched;
    logic             is_wr;
    logic             err_r;
    logic [LEN_W-1:0] byte_cnt;
    logic [PW-1:0]    poll_cnt;

    logic [15:0]      cur_addr;
    logic [LEN_W-1:0] chunk_len;
    logic             last_chunk;
    logic             gap_expired;

    logic byte_state, fire, step, last_byte, poll_busy, poll_out;

    assign byte_state = (state == ST_WREN) || (state == ST_OPC) || (state == ST_AHI) ||
                        (state == ST_ALO)  || (state == ST_DATA) ||
                        (state == ST_PSTAT) || (state == ST_PDUM);
    assign fire      = byte_state && !launched;
    assign step      = byte_state && launched && xfer_done;
    assign last_byte = (byte_cnt == chunk_len - 1'b1);
    assign poll_busy = xfer_rx[0];
    assign poll_out  = (poll_cnt == PW'(POLL_MAX - 1));

    spi_eep_chunker #(.CHUNK(CHUNK), .LEN_W(LEN_W)) u_chunker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state == ST_IDLE && req_valid),
        .adv       (state == ST_ADV),
        .addr_in   (req_addr),
        .len_in    (req_len),
        .cur_addr  (cur_addr),
        .chunk_len (chunk_len),
        .last_chunk(last_chunk)
    );

    spi_eep_gap #(.CYCLES(GAP_CYC)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state == ST_PDUM && step && poll_busy && !poll_out),
        .expired(gap_expired)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = (req_len == '0) ? ST_FIN :
                                           (req_write ? ST_WREN : ST_OPC);
            ST_WREN:  if (step) nxt = ST_OPC;
            ST_OPC:   if (step) nxt = ST_AHI;
            ST_AHI:   if (step) nxt = ST_ALO;
            ST_ALO:   if (step) nxt = ST_DATA;
            ST_DATA:  if (step && last_byte) nxt = is_wr ? ST_PSTAT : ST_ADV;
            ST_PSTAT: if (step) nxt = ST_PDUM;
            ST_PDUM:  if (step) nxt = !poll_busy ? ST_ADV : (poll_out ? ST_FIN : ST_GAP);
            ST_GAP:   if (gap_expired) nxt = ST_PSTAT;
            ST_ADV:   nxt = last_chunk ? ST_FIN : (is_wr ? ST_WREN : ST_OPC);
            ST_FIN:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register and the counters that follow it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            launched <= 1'b0;
            is_wr    <= 1'b0;
            err_r    <= 1'b0;
            byte_cnt <= '0;
            poll_cnt <= '0;
        end else begin
            state <= nxt;
            if (fire)      launched <= 1'b1;
            else if (step) launched <= 1'b0;
            if (state == ST_IDLE && req_valid) begin
                is_wr <= req_write;
                err_r <= 1'b0;
            end
            if (state == ST_OPC)                byte_cnt <= '0;
            else if (state == ST_DATA && step)  byte_cnt <= byte_cnt + 1'b1;
            if (state == ST_WREN)               poll_cnt <= '0;
            else if (state == ST_PDUM && step)  poll_cnt <= poll_cnt + 1'b1;
            if (state == ST_PDUM && step && poll_busy && poll_out) err_r <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        xfer_tx      = FILL_BYTE;
        xfer_hold_cs = 1'b1;
        unique case (state)
            ST_WREN:  begin xfer_tx = OP_WR_ENABLE; xfer_hold_cs = 1'b0; end
            ST_OPC:   xfer_tx = is_wr ? OP_WRITE : OP_READ;
            ST_AHI:   xfer_tx = cur_addr[15:8];
            ST_ALO:   xfer_tx = cur_addr[7:0];
            ST_DATA:  begin
                xfer_tx      = is_wr ? wdata : FILL_BYTE;
                xfer_hold_cs = !last_byte;
            end
            ST_PSTAT: xfer_tx = OP_STATUS;
            ST_PDUM:  xfer_hold_cs = 1'b0;
            default:  ;
        endcase
        xfer_start  = fire;
        wdata_take  = fire && state == ST_DATA && is_wr;
        rdata_valid = step && state == ST_DATA && !is_wr;
        rdata       = xfer_rx;
        busy        = (state != ST_IDLE);
        done        = (state == ST_FIN);
        err         = (state == ST_FIN) && err_r;
    end

endmodule

// File: rtl/spi_eep_seq_chk.sv
module spi_eep_seq_chk #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             xfer_start,
    input logic             xfer_done,
    input logic             wdata_take,
    input logic             rdata_valid
);
    logic outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          outstanding <= 1'b0;
        else if (xfer_start) outstanding <= 1'b1;
        else if (xfer_done)  outstanding <= 1'b0;
    end

    a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !xfer_start);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!xfer_start && !wdata_take && !rdata_valid && !done));

    a_r1_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_len == '0) |=> (done && !err));

    a_r4_rd_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> xfer_done);

    a_r3_take_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_take |-> xfer_start);

    a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

endmodule

bind spi_eep_seq spi_eep_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_len    (req_len),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .xfer_start (xfer_start),
    .xfer_done  (xfer_done),
    .wdata_take (wdata_take),
    .rdata_valid(rdata_valid)
);

// File: tb/test_spi_eep_seq.sv
module test_spi_eep_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 8;
    localparam int CHUNK      = 16;
    localparam int POLLS      = 4;
    localparam int CLK_HZ     = 16000;
    localparam int GAP        = CLK_HZ / 1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0, req_write = 1'b0;
    logic [15:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             busy, done, err;
    logic [7:0]       wdata;
    logic             wdata_take;
    logic [7:0]       rdata;
    logic             rdata_valid;
    logic             xfer_start, xfer_hold_cs;
    logic [7:0]       xfer_tx;
    logic             xfer_done = 1'b0;
    logic [7:0]       xfer_rx = '0;

    logic [7:0]  wbuf [64];
    logic [7:0]  wlog [64];
    logic [7:0]  rbuf [64];
    logic [7:0]  log_op [64];
    int          log_len [64];
    logic [15:0] log_addr [64];
    int          log_t [64];
    int nlog = 0, wn = 0, rn = 0, widx = 0, pos = 0, lat = 0, cyc = 0, t0 = 0;
    int busy_left = 0, busy_cfg = 0;
    logic [7:0] op = '0, ahi = '0, alo = '0, pend_rx = '0;
    int checks = 0, fails = 0;

    assign wdata = wbuf[widx[5:0]];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_eep_seq #(.CLK_HZ(CLK_HZ), .POLL_MAX(POLLS), .CHUNK(CHUNK), .LEN_W(LEN_W)) i_spi_eep_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done), .err(err),
        .wdata(wdata), .wdata_take(wdata_take), .rdata(rdata), .rdata_valid(rdata_valid),
        .xfer_start(xfer_start), .xfer_tx(xfer_tx), .xfer_hold_cs(xfer_hold_cs),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // byte engine and EEPROM model, all on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (xfer_done) xfer_done = 1'b0;
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    xfer_done = 1'b1;
                    xfer_rx   = pend_rx;
                    #1;
                    if (rdata_valid && rn < 64) begin
                        rbuf[rn] = rdata;
                        rn++;
                    end
                end
            end
            if (xfer_start) begin
                logic [7:0] tx;
                tx = xfer_tx;
                if (pos == 0) begin op = tx; t0 = cyc; end
                if (pos == 1) ahi = tx;
                if (pos == 2) alo = tx;
                pend_rx = 8'hFF;
                if (op == 8'h03 && pos >= 3) pend_rx = memf({ahi, alo} + 16'(pos - 3));
                if (op == 8'h05 && pos == 1) begin
                    pend_rx = (busy_left > 0) ? 8'hF1 : 8'hF0;
                    if (busy_left > 0) busy_left--;
                end
                if (op == 8'h02 && pos >= 3 && wn < 64) begin wlog[wn] = tx; wn++; end
                if (wdata_take) widx++;
                if (!xfer_hold_cs) begin
                    if (nlog < 64) begin
                        log_op[nlog] = op; log_len[nlog] = pos + 1;
                        log_addr[nlog] = {ahi, alo}; log_t[nlog] = t0;
                        nlog++;
                    end
                    if (op == 8'h02) busy_left = busy_cfg;
                    pos = 0;
                end else begin
                    pos++;
                end
                lat = 3;
            end
        end
    end

    task automatic clear_log();
        nlog = 0; wn = 0; rn = 0; widx = 0; pos = 0;
    endtask

    task automatic issue(input bit w, input logic [15:0] a, input int len);
        req_write = w; req_addr = a; req_len = LEN_W'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit e);
        int t;
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        check(done, "R10 request completes with done", done, 1);
        e = err;
        @(negedge clk);
    endtask

    task automatic exp_txn(inout int k, input logic [7:0] o, input int l,
                           input logic [15:0] a, input bit chk_a, input string tag);
        int j;
        j = (k < 63) ? k : 63;
        check(k < nlog && log_op[j] == o, {tag, " opcode"}, log_op[j], o);
        check(log_len[j] == l, "R9 transaction length", log_len[j], l);
        if (chk_a) check(log_addr[j] == a, "R8 chunk address", log_addr[j], a);
        k++;
    endtask

    task automatic t_reset();
        check(!busy && !done && !err && !xfer_start, "R11 reset state",
              {busy, done, err, xfer_start}, 0);
    endtask

    task automatic t_zero();
        clear_log();
        issue(1'b1, 16'h0500, 0);
        check(done && !err, "R1 zero length done next cycle", {done, err}, 2);
        repeat (3) @(negedge clk);
        check(nlog == 0 && !busy, "R1 zero length sends nothing", nlog, 0);
    endtask

    task automatic t_write(input logic [15:0] a, input int len, input int bc);
        bit e;
        int k, rem, cl;
        logic [15:0] ad;
        clear_log();
        busy_cfg = bc;
        for (int i = 0; i < 64; i++) wbuf[i] = 8'(i * 7 + int'(a[3:0]) + 1);
        issue(1'b1, a, len);
        wait_done(e);
        check(!e, "R5 write completes without error", e, 0);
        k = 0; rem = len; ad = a;
        while (rem > 0) begin
            cl = (rem > CHUNK) ? CHUNK : rem;
            exp_txn(k, 8'h06, 1, 16'h0, 1'b0, "R2 write enable");
            exp_txn(k, 8'h02, 3 + cl, ad, 1'b1, "R3 write command");
            for (int p = 0; p <= bc; p++) begin
                if (p > 0 && k < 64)
                    check(log_t[k] - log_t[k-1] >= GAP, "R6 poll spacing",
                          log_t[k] - log_t[k-1], GAP);
                exp_txn(k, 8'h05, 2, 16'h0, 1'b0, "R5 status poll");
            end
            ad = ad + 16'(cl);
            rem = rem - cl;
        end
        check(nlog == k, "R8 transaction count", nlog, k);
        check(wn == len, "R3 data byte count", wn, len);
        for (int i = 0; i < len && i < 64; i++)
            check(wlog[i] == wbuf[i], "R3 data order", wlog[i], wbuf[i]);
    endtask

    task automatic t_read(input logic [15:0] a, input int len, input bit poke);
        bit e;
        int k, rem, cl;
        logic [15:0] ad;
        clear_log();
        issue(1'b0, a, len);
        if (poke) begin
            repeat (8) @(negedge clk);
            issue(1'b1, 16'h0000, 3);
        end
        wait_done(e);
        check(!e, "R4 read completes without error", e, 0);
        if (poke) check(widx == 0, "R10 request while busy ignored", widx, 0);
        k = 0; rem = len; ad = a;
        while (rem > 0) begin
            cl = (rem > CHUNK) ? CHUNK : rem;
            exp_txn(k, 8'h03, 3 + cl, ad, 1'b1, "R4 read command");
            ad = ad + 16'(cl);
            rem = rem - cl;
        end
        check(nlog == k, "R8 read transaction count", nlog, k);
        check(rn == len, "R4 read byte count", rn, len);
        for (int i = 0; i < len && i < 64; i++)
            check(rbuf[i] == memf(a + 16'(i)), "R4 read data", rbuf[i], memf(a + 16'(i)));
    endtask

    task automatic t_timeout();
        bit e;
        int k;
        clear_log();
        busy_cfg = 100;
        for (int i = 0; i < 64; i++) wbuf[i] = 8'(i);
        issue(1'b1, 16'h0040, 2);
        wait_done(e);
        check(e, "R7 timeout raises err", e, 1);
        repeat (10) @(negedge clk);
        k = 0;
        exp_txn(k, 8'h06, 1, 16'h0, 1'b0, "R2 write enable");
        exp_txn(k, 8'h02, 5, 16'h0040, 1'b1, "R3 write command");
        for (int p = 0; p < POLLS; p++) exp_txn(k, 8'h05, 2, 16'h0, 1'b0, "R7 status poll");
        check(nlog == k, "R7 no traffic after timeout", nlog, k);
        busy_cfg = 0;
        busy_left = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_write(16'h1234, 5, 2);
        t_write(16'h00F8, 20, 0);
        t_read(16'hFFF0, 37, 1'b1);
        t_read(16'h0100, 1, 1'b0);
        t_timeout();
        t_write(16'h0200, 16, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule